// File: doc/BRIEF.md
# Cascadable Up/Down Decade Counter Stage

This block is one digit of a synchronous decimal counter. A 4-bit state register changes only on the rising clock edge. On each edge it does one of three things. It takes a preset value from the data input when the active-low load is asserted. It steps one place up or down when both active-low count enables are asserted and no load is pending. Otherwise it keeps its value. The direction input picks the step direction. An up step wraps from nine to zero, and a down step wraps from zero to nine.

The active-low carry output lets several stages form a wider counter with no extra gates. Carry is decoded combinationally from the present state, the direction and the carry-gating enable. It goes low while the digit sits at its terminal value: nine when counting up, zero when counting down. Only the T enable gates it. To chain stages, the P enable is wired in parallel to every stage. Each stage's T enable is driven by the carry of the stage below it. The top stage then advances on the edge where every lower digit rolls over.

The width and the modulus are parameters. With a modulus equal to two to the power of the width, the block builds a plain binary wrap instead of the decade variant.

Top module: `bcd_updown_stage`

## Requirements
- R1: The state changes only at a rising clock edge. Values that the control or data inputs take between edges, and then drop before the edge, leave the state unchanged.
- R2: When load_n is 0 at an edge, q takes d on that edge, whatever the enables and direction are.
- R3: When load_n is 1 and either en_p_n or en_t_n is 1 at an edge, q keeps its value.
- R4: When load_n is 1, en_p_n is 0, en_t_n is 0 and up_dn is 1, q goes from 9 to 0, and from any other value v to (v+1) mod 16.
- R5: When load_n is 1, en_p_n is 0, en_t_n is 0 and up_dn is 0, q goes from 0 to 9, and from any other value v to v-1.
- R6: carry_n is 1 whenever en_t_n is 1.
- R7: With up_dn at 1 and en_t_n at 0, carry_n is 0 exactly while q equals 9.
- R8: With up_dn at 0 and en_t_n at 0, carry_n is 0 exactly while q equals 0.
- R9: After a load of a value from 10 to 15, carry_n stays 1 in both directions, and counting follows R4 and R5. An up step from 15 gives 0.
- R10: Two stages chained as follows count from 00 to 99 and wrap in both directions: a shared P enable, the lower stage's carry_n driving the upper stage's en_t_n, and a shared direction input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| load_n | input | 1 | Synchronous preset, active low; overrides counting |
| en_p_n | input | 1 | Count enable, active low; has no effect on carry |
| en_t_n | input | 1 | Count enable, active low; also gates carry_n |
| up_dn | input | 1 | Count direction: 1 for up, 0 for down |
| d | input | WIDTH (4) | Preset value |
| q | output | WIDTH (4) | Counter state |
| carry_n | output | 1 | Terminal-count flag, active low, combinational |

## Verification
A load and a count can be requested in the same cycle. This happens when load_n is 0 while both enables are also 0. The bench sets up this case for every start value, in both directions. It loads a known digit and then applies all eight combinations of load_n and the two enables. It compares the digit after the edge with an arithmetic model in which the preset always wins. The two-stage sweep checks the second collision: the lower digit wraps on the same edge on which the upper digit steps. After each edge, both digits are compared against an integer taken modulo one hundred.

// File: rtl/bcd_ctr_pkg.sv
package bcd_ctr_pkg;

   // Action chosen for the state register at the next rising edge.
   typedef enum logic [1:0] {
      OP_HOLD = 2'd0,
      OP_LOAD = 2'd1,
      OP_INC  = 2'd2,
      OP_DEC  = 2'd3
   } ctr_op_e;

endpackage

// File: rtl/bcd_ctr_ctl.sv
module bcd_ctr_ctl
   import bcd_ctr_pkg::*;
(
   input  logic    load_n,
   input  logic    en_p_n,
   input  logic    en_t_n,
   input  logic    up_dn,
   output ctr_op_e op
);

   logic run;

   assign run = ~en_p_n & ~en_t_n;

   // The preset has priority over counting; the direction matters only when running.
   always_comb begin
      if (!load_n)
         op = OP_LOAD;
      else if (run)
         op = up_dn ? OP_INC : OP_DEC;
      else
         op = OP_HOLD;
   end

endmodule

// File: rtl/bcd_ctr_step.sv
module bcd_ctr_step
   import bcd_ctr_pkg::*;
#(
   parameter int WIDTH   = 4,
   parameter int MODULUS = 10
)(
   input  logic [WIDTH-1:0] cur,
   input  logic [WIDTH-1:0] din,
   input  ctr_op_e          op,
   output logic [WIDTH-1:0] nxt
);

   localparam logic [WIDTH-1:0] LAST = WIDTH'(MODULUS - 1);
   localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
   localparam bit FULL_RANGE = (MODULUS == (1 << WIDTH));

   logic [WIDTH-1:0] inc_v;
   logic [WIDTH-1:0] dec_v;

   generate
      if (FULL_RANGE) begin : g_binary
         // The natural overflow of the adder already gives the wrap.
         assign inc_v = cur + ONE;
         assign dec_v = cur - ONE;
      end else begin : g_modulo
         // Values above LAST step as plain binary, so an out-of-range preset drifts back in.
         assign inc_v = (cur == LAST)     ? '0   : cur + ONE;
         assign dec_v = (cur == '0)       ? LAST : cur - ONE;
      end
   endgenerate

   always_comb begin
      unique case (op)
         OP_LOAD: nxt = din;
         OP_INC:  nxt = inc_v;
         OP_DEC:  nxt = dec_v;
         default: nxt = cur;
      endcase
   end

endmodule

// File: rtl/bcd_ctr_term.sv
module bcd_ctr_term #(
   parameter int WIDTH   = 4,
   parameter int MODULUS = 10
)(
   input  logic [WIDTH-1:0] cur,
   input  logic             up_dn,
   input  logic             en_t_n,
   output logic             carry_n
);

   localparam logic [WIDTH-1:0] LAST = WIDTH'(MODULUS - 1);

   logic at_top;
   logic at_bottom;
   logic edge_hit;

   assign at_top    = (cur == LAST);
   assign at_bottom = (cur == '0);
   assign edge_hit  = up_dn ? at_top : at_bottom;
   assign carry_n   = ~(edge_hit & ~en_t_n);

endmodule

// File: rtl/bcd_updown_stage.sv
module bcd_updown_stage
   import bcd_ctr_pkg::*;
#(
   parameter int WIDTH   = 4,
   parameter int MODULUS = 10
)(
   input  logic             clk,
   input  logic             load_n,
   input  logic             en_p_n,
   input  logic             en_t_n,
   input  logic             up_dn,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q,
   output logic             carry_n
);

   localparam logic [WIDTH-1:0] LAST = WIDTH'(MODULUS - 1);

   generate
      if (WIDTH < 1 || WIDTH > 16) begin : g_bad_width
         $error("bcd_updown_stage: WIDTH must lie in 1..16");
      end
      if (MODULUS < 2 || MODULUS > (1 << WIDTH)) begin : g_bad_mod
         $error("bcd_updown_stage: MODULUS must lie in 2..2**WIDTH");
      end
   endgenerate

   ctr_op_e          op;
   logic [WIDTH-1:0] q_r;
   logic [WIDTH-1:0] q_nxt;

   bcd_ctr_ctl u_ctl (
      .load_n (load_n),
      .en_p_n (en_p_n),
      .en_t_n (en_t_n),
      .up_dn  (up_dn),
      .op     (op)
   );

   bcd_ctr_step #(.WIDTH(WIDTH), .MODULUS(MODULUS)) u_step (
      .cur (q_r),
      .din (d),
      .op  (op),
      .nxt (q_nxt)
   );

   bcd_ctr_term #(.WIDTH(WIDTH), .MODULUS(MODULUS)) u_term (
      .cur     (q_r),
      .up_dn   (up_dn),
      .en_t_n  (en_t_n),
      .carry_n (carry_n)
   );

   // All state bits share one edge.
   always_ff @(posedge clk) begin
      q_r <= q_nxt;
   end

   assign q = q_r;

   // Checking only: marks that at least one edge has passed.
   logic primed = 1'b0;
   always_ff @(posedge clk) primed <= 1'b1;

   p_load_wins_r2: assert property (@(posedge clk) disable iff (!primed)
      !load_n |=> (q == $past(d)));

   p_hold_r3: assert property (@(posedge clk) disable iff (!primed)
      (load_n && (en_p_n || en_t_n)) |=> $stable(q));

   p_up_wrap_r4: assert property (@(posedge clk) disable iff (!primed)
      (load_n && !en_p_n && !en_t_n && up_dn && q == LAST) |=> (q == '0));

   p_down_wrap_r5: assert property (@(posedge clk) disable iff (!primed)
      (load_n && !en_p_n && !en_t_n && !up_dn && q == '0) |=> (q == LAST));

   p_carry_gated_r6: assert property (@(posedge clk) disable iff (!primed)
      en_t_n |-> carry_n);

   p_carry_then_wrap_r7: assert property (@(posedge clk) disable iff (!primed)
      (!carry_n && load_n && !en_p_n) |=> (q == ($past(up_dn) ? '0 : LAST)));

   p_carry_direction_r8: assert property (@(posedge clk) disable iff (!primed)
      (!carry_n && !up_dn) |-> (q == '0));

endmodule

// File: tb/bcd_updown_stage_test.sv
module bcd_updown_stage_test;

   logic       clk = 1'b0;
   logic       load_n = 1'b0;
   logic       en_p_n = 1'b1;
   logic       en_t_n = 1'b1;
   logic       up_dn  = 1'b1;
   logic [3:0] d      = 4'd0;
   logic [3:0] q;
   logic       carry_n;

   // Cascade pair
   logic       c_load_n = 1'b0;
   logic       c_run_n  = 1'b1;
   logic       c_up     = 1'b1;
   logic [3:0] c_d_lo   = 4'd0;
   logic [3:0] c_d_hi   = 4'd0;
   logic [3:0] q_lo, q_hi;
   logic       cy_lo, cy_hi;

   int total = 0;
   int bad   = 0;
   bit ended = 0;

   always #5 clk = ~clk;

   bcd_updown_stage uut (
      .clk(clk), .load_n(load_n), .en_p_n(en_p_n), .en_t_n(en_t_n),
      .up_dn(up_dn), .d(d), .q(q), .carry_n(carry_n)
   );

   bcd_updown_stage u_lo (
      .clk(clk), .load_n(c_load_n), .en_p_n(c_run_n), .en_t_n(c_run_n),
      .up_dn(c_up), .d(c_d_lo), .q(q_lo), .carry_n(cy_lo)
   );

   bcd_updown_stage u_hi (
      .clk(clk), .load_n(c_load_n), .en_p_n(c_run_n), .en_t_n(cy_lo),
      .up_dn(c_up), .d(c_d_hi), .q(q_hi), .carry_n(cy_hi)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int model_next(int v, bit ld, bit pn, bit tn, bit up, int din);
      if (!ld) return din;
      if (pn || tn) return v;
      if (up) return (v == 9) ? 0 : (v + 1) % 16;
      return (v == 0) ? 9 : v - 1;
   endfunction

   function automatic int model_carry(int v, bit tn, bit up);
      if (tn) return 1;
      if (up) return (v == 9) ? 0 : 1;
      return (v == 0) ? 0 : 1;
   endfunction

   // Advance one edge; inputs change and outputs are read 1 ns after it.
   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
   end

   initial begin
      int m;
      int cnt;
      // Reset state through the preset (R2)
      tick();
      chk("R2 reset preset", int'(q), 0);

      // R1: glitch a load and a count between edges, then withdraw both
      load_n = 1'b0; d = 4'd6; tick();
      chk("R2 preset 6", int'(q), 6);
      load_n = 1'b1; en_p_n = 1'b1; en_t_n = 1'b1;
      #1 load_n = 1'b0; d = 4'd3;
      #1 chk("R1 no change mid-cycle", int'(q), 6);
      #1 load_n = 1'b1; en_p_n = 1'b0; en_t_n = 1'b0;
      #1 en_p_n = 1'b1; en_t_n = 1'b1;
      tick();
      chk("R1 state kept after withdrawn inputs", int'(q), 6);

      // Exhaustive: every start value, direction and control combination
      for (int s = 0; s < 16; s++) begin
         for (int u = 0; u < 2; u++) begin
            for (int c = 0; c < 8; c++) begin
               load_n = 1'b0; en_p_n = 1'b1; en_t_n = 1'b1; d = 4'(s);
               tick();
               chk("R2 preset start", int'(q), s);
               load_n = c[2]; en_p_n = c[1]; en_t_n = c[0]; up_dn = u[0];
               d = 4'((s * 7 + 3) % 16);
               #1;
               m = model_carry(s, c[0], u[0]);
               if (c[0])
                  chk("R6 carry gated by en_t_n", int'(carry_n), m);
               else if (s > 9)
                  chk("R9 carry high out of range", int'(carry_n), m);
               else if (u[0])
                  chk("R7 up carry", int'(carry_n), m);
               else
                  chk("R8 down carry", int'(carry_n), m);
               m = model_next(s, c[2], c[1], c[0], u[0], (s * 7 + 3) % 16);
               tick();
               if (!c[2])
                  chk("R2 preset overrides count", int'(q), m);
               else if (c[1] || c[0])
                  chk("R3 hold", int'(q), m);
               else if (s > 9)
                  chk("R9 out-of-range step", int'(q), m);
               else if (u[0])
                  chk("R4 up step", int'(q), m);
               else
                  chk("R5 down step", int'(q), m);
            end
         end
      end

      // Cascade: count up through 00..99 and around
      c_load_n = 1'b0; c_d_lo = 4'd0; c_d_hi = 4'd0; c_up = 1'b1;
      tick();
      c_load_n = 1'b1; c_run_n = 1'b0;
      cnt = 0;
      chk("R10 cascade preset", int'(q_hi) * 10 + int'(q_lo), 0);
      for (int i = 0; i < 205; i++) begin
         tick();
         cnt = (cnt + 1) % 100;
         chk("R10 cascade up", int'(q_hi) * 10 + int'(q_lo), cnt);
      end
      c_up = 1'b0;
      for (int i = 0; i < 205; i++) begin
         tick();
         cnt = (cnt + 99) % 100;
         chk("R10 cascade down", int'(q_hi) * 10 + int'(q_lo), cnt);
      end
      // Upper carry at 00 counting down marks the whole chain at its floor
      c_run_n = 1'b1;
      c_load_n = 1'b0; c_d_lo = 4'd0; c_d_hi = 4'd0;
      tick();
      c_load_n = 1'b1; c_run_n = 1'b0;
      #1 chk("R10 chain carry at 00 down", int'(cy_hi), 0);

      finish_run();
   end

endmodule